// File: doc/BRIEF.md
# Associative Translation Entry Search

This block holds a small table of address-translation tags in flip-flops and searches all of them at once for a given 64-bit virtual address and address-space identifier. Every entry is compared in parallel in a single cycle. The lowest-numbered matching entry is reported as a registered hit flag together with its index. The index is what a later stage uses to fetch the physical frame and the permission bits. Those later stages are not part of this block.

Each entry stores a 2-bit address region, a 27-bit virtual page-pair number, a 16-bit page-size mask, an address-space identifier and a global flag. Each entry also has a hidden valid bit, which reset clears and any write sets. One write port replaces one indexed entry per clock edge. A search in the same cycle as a write still sees the old contents of the table.

Top module: `tlb_cam_search`

## Requirements
- R1: After reset every entry is invalid. The outputs read `hit_o`=0 and `idx_o`=0, and no lookup hits, including address 0 with identifier 0, until an entry has been written.
- R2: The lookup region is `lk_va[63:62]` and the lookup page-pair number is `lk_va[39:13]` (27 bits). Bits 61..40 and 12..0 have no effect on the result.
- R3: The entry mask is zero-extended to 27 bits and inverted. Both the lookup and the stored page-pair numbers are ANDed with it before the compare, so a set mask bit k makes page-pair bit k a don't-care.
- R4: A non-global entry matches only when `lk_asid` equals its stored identifier. An entry with the global flag set matches for any `lk_asid`.
- R5: An entry matches only when its stored region equals the lookup region.
- R6: When several entries match, `idx_o` reports the lowest matching index.
- R7: On a miss `hit_o` is 0 and `idx_o` is 0.
- R8: The result for the lookup inputs present before a rising clock edge appears on `hit_o`/`idx_o` after that edge, and holds until the next edge.
- R9: When `wr_en` is 1 at an edge, entry `wr_idx` takes all the written fields and becomes valid. A lookup sampled at that same edge uses the old table; the lookup at the next edge uses the new entry.
- R10: Writing an entry again replaces all of its fields, so the old tag no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write one entry at this edge |
| wr_idx | input | IDX_W | Entry to write |
| wr_region | input | 2 | Region to store |
| wr_vpn2 | input | 27 | Page-pair number to store |
| wr_pmask | input | 16 | Page-size mask to store |
| wr_asid | input | ASID_W | Identifier to store |
| wr_global | input | 1 | Global flag to store |
| lk_va | input | 64 | Virtual address to search |
| lk_asid | input | ASID_W | Current address-space identifier |
| hit_o | output | 1 | Registered hit flag |
| idx_o | output | IDX_W | Registered index of the lowest matching entry, 0 on miss |

## Verification
Each lookup result is due exactly one rising edge after its inputs are driven. A write takes effect at the same edge, but only lookups driven after that edge see it. The bench drives all inputs on the falling edge and computes the expected result from its own model of the table before it applies that cycle's write. It samples the outputs on the following falling edge, half a period after the edge that registered them. Write-then-search pairs are issued back to back, so the cycle in which a new entry becomes visible is checked directly.

// File: rtl/tlb_cam_pkg.sv
package tlb_cam_pkg;
  localparam int REGION_W = 2;
  localparam int VPN2_W   = 27;
  localparam int PMASK_W  = 16;
  localparam int VA_W     = 64;
  localparam int VPN_LO   = 13;
  localparam int VPN_HI   = VPN_LO + VPN2_W - 1;

  typedef struct packed {
    logic                valid;
    logic [REGION_W-1:0] region;
    logic [VPN2_W-1:0]   vpn2;
    logic [PMASK_W-1:0]  pmask;
    logic                glob;
  } tlb_tag_t;

  function automatic logic [VPN2_W-1:0] strip_vpn(input logic [VPN2_W-1:0] v,
                                                  input logic [PMASK_W-1:0] m);
    return v & ~{{(VPN2_W-PMASK_W){1'b0}}, m};
  endfunction
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_b
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_b = sync_q[1];
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_cam_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                           clk,
  input  logic                           rst_b,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  tlb_tag_t                       wr_tag,
  input  logic [ASID_W-1:0]              wr_asid,
  output tlb_tag_t [NUM_ENT-1:0]         tags_o,
  output logic [NUM_ENT-1:0][ASID_W-1:0] asids_o
);
  tlb_tag_t [NUM_ENT-1:0]         tags_q;
  tlb_tag_t [NUM_ENT-1:0]         tags_d;
  logic [NUM_ENT-1:0][ASID_W-1:0] asids_q;
  logic [NUM_ENT-1:0][ASID_W-1:0] asids_d;
  logic [NUM_ENT-1:0]             ent_we;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    always_comb begin
      ent_we[i]  = wr_en && (wr_idx == IDX_W'(i));
      tags_d[i]  = tags_q[i];
      asids_d[i] = asids_q[i];
      if (ent_we[i]) begin
        tags_d[i]       = wr_tag;
        tags_d[i].valid = 1'b1;
        asids_d[i]      = wr_asid;
      end
    end

    always_ff @(posedge clk or negedge rst_b) begin
      if (!rst_b) begin
        tags_q[i]  <= '0;
        asids_q[i] <= '0;
      end else if (ent_we[i]) begin
        tags_q[i]  <= tags_d[i];
        asids_q[i] <= asids_d[i];
      end
    end
  end

  assign tags_o  = tags_q;
  assign asids_o = asids_q;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_b)
    wr_en |=> tags_q[$past(wr_idx)].valid &&
              (tags_q[$past(wr_idx)].vpn2 == $past(wr_tag.vpn2)) &&
              (asids_q[$past(wr_idx)] == $past(wr_asid))); // R9
endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array
  import tlb_cam_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int ASID_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_b,
  input  tlb_tag_t [NUM_ENT-1:0]         tags_i,
  input  logic [NUM_ENT-1:0][ASID_W-1:0] asids_i,
  input  logic [REGION_W-1:0]            lk_region,
  input  logic [VPN2_W-1:0]              lk_vpn2,
  input  logic [ASID_W-1:0]              lk_asid,
  output logic [NUM_ENT-1:0]             match_o
);
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    logic region_eq;
    logic vpn_eq;
    logic asid_ok;

    always_comb begin
      region_eq  = tags_i[i].region == lk_region;
      vpn_eq     = strip_vpn(lk_vpn2, tags_i[i].pmask) ==
                   strip_vpn(tags_i[i].vpn2, tags_i[i].pmask);
      asid_ok    = tags_i[i].glob || (asids_i[i] == lk_asid);
      match_o[i] = tags_i[i].valid && region_eq && vpn_eq && asid_ok;
    end

    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_b)
      match_o[i] |-> tags_i[i].valid); // R1
    AST_MATCH_NEEDS_REGION: assert property (@(posedge clk) disable iff (!rst_b)
      match_o[i] |-> (tags_i[i].region == lk_region)); // R5
  end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int NUM_ENT = 16,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_b,
  input  logic [NUM_ENT-1:0] match_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  AST_PICK_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_b)
    any_o |-> match_i[idx_o]); // R6
  AST_PICK_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_b)
    any_o |-> ((match_i & ((NUM_ENT'(1) << idx_o) - NUM_ENT'(1))) == '0)); // R6
endmodule

// File: rtl/tlb_cam_search.sv
module tlb_cam_search
  import tlb_cam_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [1:0]          wr_region,
  input  logic [26:0]         wr_vpn2,
  input  logic [15:0]         wr_pmask,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic                wr_global,
  input  logic [63:0]         lk_va,
  input  logic [ASID_W-1:0]   lk_asid,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic                           rst_b;
  tlb_tag_t                       wr_tag;
  tlb_tag_t [NUM_ENT-1:0]         tags;
  logic [NUM_ENT-1:0][ASID_W-1:0] asids;
  logic [NUM_ENT-1:0]             match;
  logic                           any_match;
  logic [IDX_W-1:0]               pick_idx;
  logic [REGION_W-1:0]            lk_region;
  logic [VPN2_W-1:0]              lk_vpn2;
  logic                           hit_d;
  logic                           hit_q;
  logic [IDX_W-1:0]               idx_d;
  logic [IDX_W-1:0]               idx_q;

  tlb_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_b (rst_b)
  );

  always_comb begin
    wr_tag.valid  = 1'b1;
    wr_tag.region = wr_region;
    wr_tag.vpn2   = wr_vpn2;
    wr_tag.pmask  = wr_pmask;
    wr_tag.glob   = wr_global;
    lk_region     = lk_va[VA_W-1 -: REGION_W];
    lk_vpn2       = lk_va[VPN_HI:VPN_LO];
  end

  tlb_entry_store #(.NUM_ENT(NUM_ENT), .ASID_W(ASID_W)) u_store (
    .clk     (clk),
    .rst_b   (rst_b),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .wr_asid (wr_asid),
    .tags_o  (tags),
    .asids_o (asids)
  );

  tlb_match_array #(.NUM_ENT(NUM_ENT), .ASID_W(ASID_W)) u_match (
    .clk       (clk),
    .rst_b     (rst_b),
    .tags_i    (tags),
    .asids_i   (asids),
    .lk_region (lk_region),
    .lk_vpn2   (lk_vpn2),
    .lk_asid   (lk_asid),
    .match_o   (match)
  );

  tlb_prio_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .clk     (clk),
    .rst_b   (rst_b),
    .match_i (match),
    .any_o   (any_match),
    .idx_o   (pick_idx)
  );

  always_comb begin
    hit_d = any_match;
    idx_d = any_match ? pick_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= hit_d;
      idx_q <= idx_d;
    end
  end

  assign hit_o = hit_q;
  assign idx_o = idx_q;

  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_b)
    !hit_q |-> (idx_q == '0)); // R7
  AST_RESULT_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_b)
    hit_q == $past(any_match)); // R8
endmodule

// File: tb/sim_tlb_cam_search.sv
module sim_tlb_cam_search;
  localparam int N  = 16;
  localparam int AW = 8;
  localparam int IW = $clog2(N);

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [1:0]    wr_region;
  logic [26:0]   wr_vpn2;
  logic [15:0]   wr_pmask;
  logic [AW-1:0] wr_asid;
  logic          wr_global;
  logic [63:0]   lk_va;
  logic [AW-1:0] lk_asid;
  logic          hit_o;
  logic [IW-1:0] idx_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic          m_val [N];
  logic [1:0]    m_reg [N];
  logic [26:0]   m_vpn [N];
  logic [15:0]   m_msk [N];
  logic [AW-1:0] m_asd [N];
  logic          m_glb [N];

  tlb_cam_search #(.NUM_ENT(N), .ASID_W(AW)) u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] mk_va(input logic [1:0] r, input logic [26:0] v,
                                        input logic [21:0] mid, input logic [12:0] lo);
    return {r, mid, v, lo};
  endfunction

  function automatic logic [IW:0] ref_look(input logic [63:0] va, input logic [AW-1:0] a);
    logic [26:0] keep;
    for (int i = 0; i < N; i++) begin
      keep = ~{11'b0, m_msk[i]};
      if (m_val[i] && m_reg[i] == va[63:62] &&
          ((va[39:13] & keep) == (m_vpn[i] & keep)) &&
          (m_glb[i] || m_asd[i] == a))
        return {1'b1, IW'(i)};
    end
    return '0;
  endfunction

  task automatic check(input string req, input logic [IW:0] got, input logic [IW:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual hit=%0d idx=%0d expected hit=%0d idx=%0d",
               req, got[IW], got[IW-1:0], exp[IW], exp[IW-1:0]);
    end
  endtask

  // one cycle: drive at negedge, register at posedge, sample at next negedge
  task automatic step(input string req, input logic we, input int wi, input logic [1:0] r,
                      input logic [26:0] v, input logic [15:0] m, input logic [AW-1:0] a,
                      input logic g, input logic [63:0] va, input logic [AW-1:0] la);
    logic [IW:0] exp;
    wr_en = we; wr_idx = IW'(wi); wr_region = r; wr_vpn2 = v; wr_pmask = m;
    wr_asid = a; wr_global = g; lk_va = va; lk_asid = la;
    exp = ref_look(va, la);
    @(posedge clk);
    if (we) begin
      m_val[wi] = 1'b1; m_reg[wi] = r; m_vpn[wi] = v;
      m_msk[wi] = m; m_asd[wi] = a; m_glb[wi] = g;
    end
    @(negedge clk);
    check(req, {hit_o, idx_o}, exp);
  endtask

  task automatic look(input string req, input logic [63:0] va, input logic [AW-1:0] la,
                      input logic [IW:0] exp);
    wr_en = 1'b0; lk_va = va; lk_asid = la;
    @(posedge clk);
    @(negedge clk);
    check(req, {hit_o, idx_o}, exp);
    check({req, "_model"}, {hit_o, idx_o}, ref_look(va, la));
  endtask

  localparam logic [26:0] VA0 = 27'h1234567;
  localparam logic [26:0] VB0 = 27'h0ABCDE0;

  initial begin
    logic [26:0] pool [4];
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_reg[i] = 0; m_vpn[i] = 0; m_msk[i] = 0; m_asd[i] = 0; m_glb[i] = 0;
    end
    rst_n = 1'b0; wr_en = 0; wr_idx = 0; wr_region = 0; wr_vpn2 = 0; wr_pmask = 0;
    wr_asid = 0; wr_global = 0; lk_va = 0; lk_asid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check("R1_reset_out", {hit_o, idx_o}, '0);
    look("R1_zero_lookup", 64'd0, '0, '0);

    // R9: write and search same entry in one cycle sees old, next cycle new
    step("R9_same_cycle_old", 1, 3, 2'd2, VA0, 16'h0, 8'd5, 0,
         mk_va(2'd2, VA0, 0, 0), 8'd5);
    look("R9_next_cycle_new", mk_va(2'd2, VA0, 0, 0), 8'd5, {1'b1, IW'(3)});
    look("R2_ignored_bits", mk_va(2'd2, VA0, 22'h3FFFFF, 13'h1FFF), 8'd5, {1'b1, IW'(3)});
    look("R4_asid_mismatch", mk_va(2'd2, VA0, 0, 0), 8'd6, '0);
    look("R5_region_mismatch", mk_va(2'd1, VA0, 0, 0), 8'd5, '0);
    look("R7_miss_idx_zero", mk_va(2'd2, VA0 ^ 27'h1, 0, 0), 8'd5, '0);

    // R4 global entry at the last index
    step("R4_write_global", 1, N-1, 2'd0, VB0, 16'h0, 8'd9, 1, 64'd0, 8'd0);
    look("R4_global_any_asid", mk_va(2'd0, VB0, 0, 0), 8'd77, {1'b1, IW'(N-1)});

    // R3 mask 0x3: low two page-pair bits are don't-care
    step("R3_write_mask", 1, 7, 2'd3, 27'h00F0F00, 16'h0003, 8'd1, 0, 64'd0, 8'd0);
    look("R3_mask_low_bits", mk_va(2'd3, 27'h00F0F03, 0, 0), 8'd1, {1'b1, IW'(7)});
    look("R3_mask_bit2_kept", mk_va(2'd3, 27'h00F0F04, 0, 0), 8'd1, '0);

    // R6 overlapping entries: lowest index wins
    step("R6_write_high", 1, 12, 2'd1, 27'h0000055, 16'h0, 8'd2, 1, 64'd0, 8'd0);
    step("R6_write_low", 1, 4, 2'd1, 27'h0000055, 16'h0, 8'd2, 0, 64'd0, 8'd0);
    look("R6_lowest_index", mk_va(2'd1, 27'h0000055, 0, 0), 8'd2, {1'b1, IW'(4)});
    look("R6_only_global", mk_va(2'd1, 27'h0000055, 0, 0), 8'd3, {1'b1, IW'(12)});

    // R10 overwrite entry 4 with another tag
    step("R10_overwrite", 1, 4, 2'd0, 27'h7000000, 16'h0, 8'd2, 0, 64'd0, 8'd0);
    look("R10_old_tag_gone", mk_va(2'd1, 27'h0000055, 0, 0), 8'd3, {1'b1, IW'(12)});
    look("R10_new_tag", mk_va(2'd0, 27'h7000000, 0, 0), 8'd2, {1'b1, IW'(4)});

    // R8 random mix, result one edge after inputs
    pool[0] = VA0; pool[1] = VB0; pool[2] = 27'h00F0F00; pool[3] = 27'h4444444;
    for (int k = 0; k < 600; k++) begin
      logic [15:0] mk;
      logic [26:0] lv;
      case ($urandom % 4)
        0: mk = 16'h0000;
        1: mk = 16'h0003;
        2: mk = 16'h000F;
        default: mk = 16'h00FF;
      endcase
      lv = pool[$urandom % 4] ^ 27'($urandom % 16);
      step("R8_random", ($urandom % 3) == 0, int'($urandom % N), 2'($urandom),
           pool[$urandom % 4], mk, AW'($urandom % 4), ($urandom % 5) == 0,
           mk_va(2'($urandom), lv, 22'($urandom), 13'($urandom)), AW'($urandom % 4));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule